// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Persistent Address Counter

This block is a two-wire (I2C) slave in front of a 512-byte, byte-wide memory. It watches SCL and SDA and detects start, repeated start and stop conditions. It checks the device byte against a fixed 7-bit address and answers the master through an open-drain SDA pull-down enable. The master can load a 9-bit word address, write bytes, and read in three ways. A current read continues from the stored counter. A random read loads an address in a write header, then issues a repeated start and a read header. A sequential read goes on for as long as the master acknowledges each byte.

The word address counter keeps its value from one transaction to the next. The way it advances depends on the kind of access. After a read it steps through the whole array and wraps from 0x1FF to 0x000. After a write it stays inside the current 8-byte page. The counter has no defined value after power-up, so the master has to load it before it relies on a current read.

Top module: `serial_mem_slave`

## Requirements
- R1: During and right after reset, the SDA pull-down enable `sda_oe` is 0.
- R2: A device byte is transferred MSB first. Its bits [7:2] must equal `DEV_ID[6:1]`, bit 1 carries word address bit 8 and bit 0 is the direction (1 = read). When bits [7:2] match, the slave pulls SDA low for the ninth (acknowledge) clock.
- R3: When bits [7:2] of the device byte do not match, SDA stays released for the acknowledge slot and for every later bit. No counter or memory state changes until the next start condition.
- R4: In a write transaction, the byte after the device byte supplies word address bits [7:0] and is acknowledged. Each later data byte is acknowledged and stored at the counter address.
- R5: After a byte is written at address n, the counter becomes n with its low 3 bits incremented modulo 8. The upper 6 bits are kept, so the counter wraps within the 8-byte page.
- R6: A random read (write header, word address, repeated start, read header) returns the byte stored at the loaded address, MSB first, with the first bit driven right after the read header's acknowledge.
- R7: In a sequential read, a master acknowledge of 0 after a data byte causes the next byte, at the previous address + 1, to be driven. Address 0x1FF is followed by 0x000.
- R8: A current read returns the byte at n+1 following the last read of address n (0x1FF wraps to 0x000), or at the page-wrapped value following the last write.
- R9: After a master acknowledge of 1, the slave releases SDA and drives nothing until a start condition. A stop then leaves the slave idle and ready for a new transaction.
- R10: The slave changes `sda_oe` only while SCL is low.
- R11: A stop condition received in the middle of a byte ends the transaction without loading the counter or writing the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as sampled |
| sda_i | input | 1 | Serial data line as sampled (wired-AND bus level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
If the address counter goes wrong, it does not show at once. It shows on the first data bit of the next current or sequential read, which can be a whole transaction after the faulty access. For this reason the bench predicts every data bit from a behavioural memory and counter model, and it reads back right after each page-wrapping write and after each full-array rollover. A wrong FSM state shows at the next acknowledge slot, either as a missing pull-down or as a stray one. The bench checks every one of those slots. Mid-byte stops and address mismatches are each followed by a current read, so that a hidden change to the counter becomes visible.

// File: rtl/sm_pkg.sv
package sm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WA,
        ST_WA_ACK,
        ST_WD,
        ST_WD_ACK,
        ST_RD,
        ST_RACK,
        ST_SKIP
    } sm_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } sm_busev_t;

    localparam int SM_BYTE_W = 8;

    function automatic logic is_ack_slot(input sm_state_e s);
        return (s == ST_DEV_ACK) || (s == ST_WA_ACK) || (s == ST_WD_ACK);
    endfunction

endpackage

// File: rtl/sm_bus_cond.sv
module sm_bus_cond
    import sm_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output sm_busev_t ev
);
    logic [SYNC-1:0] scl_s, sda_s;
    logic            scl_p, sda_p;
    logic            scl_n, sda_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s <= '1;
            sda_s <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_s <= {scl_s[SYNC-2:0], scl_i};
            sda_s <= {sda_s[SYNC-2:0], sda_i};
            scl_p <= scl_s[SYNC-1];
            sda_p <= sda_s[SYNC-1];
        end
    end

    assign scl_n = scl_s[SYNC-1];
    assign sda_n = sda_s[SYNC-1];

    always_comb begin
        ev.start = scl_p & scl_n & sda_p & ~sda_n;
        ev.stop  = scl_p & scl_n & ~sda_p & sda_n;
        ev.rise  = ~scl_p & scl_n;
        ev.fall  = scl_p & ~scl_n;
        ev.sda   = sda_n;
    end
endmodule

// File: rtl/sm_addr_ctr.sv
module sm_addr_ctr #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              step_wr,
    input  logic              step_rd,
    output logic [ADDR_W-1:0] addr
);
    logic [PAGE_W-1:0] in_page;

    assign in_page = addr[PAGE_W-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (ld) begin
            addr <= ld_val;
        end else if (step_wr) begin
            addr <= {addr[ADDR_W-1:PAGE_W], in_page};
        end else if (step_rd) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/sm_mem.sv
module sm_mem #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import sm_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'h50,
    parameter int         ADDR_W = 9,
    parameter int         PAGE_W = 3,
    parameter int         SYNC   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int HI_W  = ADDR_W - SM_BYTE_W;
    localparam int CNT_W = 4;

    sm_busev_t             ev;
    sm_state_e             st;
    logic [CNT_W-1:0]      bcnt;
    logic [SM_BYTE_W-1:0]  sh;
    logic                  rw;
    logic                  mack;
    logic [HI_W-1:0]       hi;
    logic [ADDR_W-1:0]     ctr_addr;
    logic [SM_BYTE_W-1:0]  rd_q;
    logic                  byte_done;
    logic                  id_match;
    logic                  ld, step_wr, step_rd;

    sm_bus_cond #(.SYNC(SYNC)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    sm_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .ld      (ld),
        .ld_val  ({hi, sh}),
        .step_wr (step_wr),
        .step_rd (step_rd),
        .addr    (ctr_addr)
    );

    sm_mem #(.ADDR_W(ADDR_W), .DATA_W(SM_BYTE_W)) u_mem (
        .clk   (clk),
        .we    (step_wr),
        .addr  (ctr_addr),
        .wdata (sh),
        .rdata (rd_q)
    );

    assign byte_done = ev.fall && (bcnt == CNT_W'(8)) && !ev.start && !ev.stop;
    assign id_match  = (sh[7:HI_W+1] == DEV_ID[6:HI_W]);

    always_comb begin
        ld      = (st == ST_WA) && byte_done;
        step_wr = (st == ST_WD) && byte_done;
        step_rd = ((st == ST_DEV_ACK) && ev.fall && rw) ||
                  ((st == ST_RACK) && ev.fall && !mack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            bcnt <= '0;
            sh   <= '0;
            rw   <= 1'b0;
            mack <= 1'b1;
            hi   <= '0;
        end else if (ev.start) begin
            st   <= ST_DEV;
            bcnt <= '0;
        end else if (ev.stop) begin
            st   <= ST_IDLE;
            bcnt <= '0;
        end else begin
            unique case (st)
                ST_DEV, ST_WA, ST_WD: begin
                    if (ev.rise) begin
                        sh   <= {sh[SM_BYTE_W-2:0], ev.sda};
                        bcnt <= bcnt + 1'b1;
                    end else if (byte_done) begin
                        bcnt <= '0;
                        if (st == ST_DEV) begin
                            if (id_match) begin
                                st <= ST_DEV_ACK;
                                rw <= sh[0];
                                hi <= sh[HI_W:1];
                            end else begin
                                st <= ST_SKIP;
                            end
                        end else if (st == ST_WA) begin
                            st <= ST_WA_ACK;
                        end else begin
                            st <= ST_WD_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev.fall) begin
                        bcnt <= '0;
                        if (rw) begin
                            st <= ST_RD;
                            sh <= rd_q;
                        end else begin
                            st <= ST_WA;
                        end
                    end
                end
                ST_WA_ACK, ST_WD_ACK: begin
                    if (ev.fall) begin
                        st   <= ST_WD;
                        bcnt <= '0;
                    end
                end
                ST_RD: begin
                    if (ev.fall) begin
                        if (bcnt == CNT_W'(7)) begin
                            st   <= ST_RACK;
                            bcnt <= '0;
                        end else begin
                            sh   <= {sh[SM_BYTE_W-2:0], 1'b0};
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.rise) begin
                        mack <= ev.sda;
                    end else if (ev.fall) begin
                        if (!mack) begin
                            st   <= ST_RD;
                            sh   <= rd_q;
                            bcnt <= '0;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign sda_oe = is_ack_slot(st) || ((st == ST_RD) && !sh[SM_BYTE_W-1]);

endmodule

// File: rtl/sm_chk.sv
module sm_chk
    import sm_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_oe,
    input sm_state_e         st,
    input logic              step_wr,
    input logic              step_rd,
    input logic              ld,
    input logic [ADDR_W-1:0] addr
);
    assert_reset_release_R1: assert property (@(posedge clk)
        rst |=> !sda_oe);

    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    assert_skip_released_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP || st == ST_IDLE) |-> !sda_oe);

    assert_page_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (step_wr && !ld) |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) &&
                             (addr[PAGE_W-1:0] == $past(addr[PAGE_W-1:0]) + 1'b1));

    assert_read_step_R7: assert property (@(posedge clk) disable iff (rst)
        (step_rd && !step_wr && !ld) |=> (addr == $past(addr) + 1'b1));

    assert_no_dual_step_R4: assert property (@(posedge clk) disable iff (rst)
        !(step_wr && step_rd));
endmodule

bind serial_mem_slave sm_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .st      (st),
    .step_wr (step_wr),
    .step_rd (step_rd),
    .ld      (ld),
    .addr    (ctr_addr)
);

// File: tb/serial_mem_slave_tb.sv
module serial_mem_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [7:0] mem_m [512];
    logic [8:0] ctr_m = '0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_mem_slave u_dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, input logic exp_oe, input string req);
        wait_n(1);
        sda_m = b;
        wait_n(3);
        scl = 1'b1;
        wait_n(3);
        chk(req, int'(sda_oe), int'(exp_oe));
        wait_n(2);
        scl = 1'b0;
        wait_n(2);
    endtask

    task automatic do_start();
        wait_n(1);
        sda_m = 1'b1;
        wait_n(3);
        scl = 1'b1;
        wait_n(3);
        sda_m = 1'b0;
        wait_n(3);
        scl = 1'b0;
        wait_n(2);
    endtask

    task automatic do_stop();
        wait_n(1);
        sda_m = 1'b0;
        wait_n(3);
        scl = 1'b1;
        wait_n(3);
        sda_m = 1'b1;
        wait_n(4);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, req);
        bus_bit(1'b1, exp_ack, req);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string req);
        for (int i = 7; i >= 0; i--) bus_bit(1'b1, ~exp[i], req);
        bus_bit(mack, 1'b0, req);
    endtask

    function automatic logic [7:0] hdr(input logic a8, input logic rd);
        return {DEV[6:1], a8, rd};
    endfunction

    task automatic write_txn(input logic [8:0] a, input int n, input logic [7:0] base);
        do_start();
        send_byte(hdr(a[8], 1'b0), 1'b1, "R2 device ack");
        send_byte(a[7:0], 1'b1, "R4 word address ack");
        ctr_m = a;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = base + 8'(k * 29);
            send_byte(d, 1'b1, "R4 data ack");
            mem_m[ctr_m] = d;
            ctr_m = {ctr_m[8:3], ctr_m[2:0] + 3'd1};
        end
        do_stop();
    endtask

    task automatic read_body(input int n, input string req);
        send_byte(hdr(1'b0, 1'b1), 1'b1, "R2 read header ack");
        for (int k = 0; k < n; k++) begin
            recv_byte(mem_m[ctr_m], (k == n - 1), req);
            ctr_m = ctr_m + 9'd1;
        end
        do_stop();
        chk("R9 released after stop", int'(sda_oe), 0);
    endtask

    task automatic current_read(input int n, input string req);
        do_start();
        read_body(n, req);
    endtask

    task automatic random_read(input logic [8:0] a, input int n, input string req);
        do_start();
        send_byte(hdr(a[8], 1'b0), 1'b1, "R2 device ack");
        send_byte(a[7:0], 1'b1, "R4 word address ack");
        ctr_m = a;
        do_start();
        read_body(n, req);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        wait_n(3);
        chk("R1 oe during reset", int'(sda_oe), 0);
        rst = 1'b0;
        wait_n(3);
        chk("R1 oe after reset", int'(sda_oe), 0);

        // R5: page wraps within last page and within page 0
        write_txn(9'h1FA, 8, 8'h11);
        chk("R5 counter after wrap write", int'(ctr_m), 'h1FA);
        write_txn(9'h000, 8, 8'h40);
        // R5: ten bytes at 0x0AD overwrite 0x0AD/0x0AE after wrapping
        write_txn(9'h0AD, 10, 8'h83);
        random_read(9'h0A8, 7, "R6 R5 read of wrapped page");
        current_read(1, "R8 current after read");
        // R7: sequential across the top of the array
        random_read(9'h1FD, 5, "R7 sequential rollover");
        current_read(1, "R8 current read");
        random_read(9'h1FF, 1, "R6 single byte");
        current_read(1, "R8 wrap to zero");

        // R3: foreign device address, write and read direction
        do_start();
        send_byte({~DEV[6:1], 1'b0, 1'b0}, 1'b0, "R3 no ack");
        send_byte(8'h05, 1'b0, "R3 ignored byte");
        send_byte(8'h00, 1'b0, "R3 ignored byte");
        do_stop();
        do_start();
        send_byte({DEV[6:2], ~DEV[1], 1'b0, 1'b1}, 1'b0, "R3 no ack read");
        recv_byte(8'hFF, 1'b1, "R3 nothing driven");
        do_stop();
        current_read(1, "R3 counter untouched");

        // R11: stop inside word address byte
        do_start();
        send_byte(hdr(1'b0, 1'b0), 1'b1, "R2 device ack");
        for (int i = 0; i < 4; i++) bus_bit(1'b1, 1'b0, "R11 partial byte");
        do_stop();
        current_read(2, "R11 counter untouched");

        // R9: after NACK the slave stays quiet for further clocks
        do_start();
        send_byte(hdr(1'b0, 1'b1), 1'b1, "R2 read header ack");
        recv_byte(mem_m[ctr_m], 1'b1, "R9 read then nack");
        ctr_m = ctr_m + 9'd1;
        recv_byte(8'hFF, 1'b1, "R9 silent after nack");
        do_stop();
        current_read(1, "R9 next transaction");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule